// File: doc/BRIEF.md
# Floating-Point Mode and Exception Flag Registers

This block holds the two software-visible registers that sit beside a floating-point unit. One register sets up the unit: it selects the rounding mode and decides whether an invalid-operation event or a divide-by-zero event raises a trap. The other register gathers five sticky exception flags, one each for invalid, divide by zero, overflow, underflow and inexact. The flags are set by one-cycle event pulses from the arithmetic datapath.

Software reaches both registers through a plain register port with an address, write data, a write strobe and a read strobe. Read data is registered. A software write to the flag register changes the flags only if the same write word has its top bit set. That top bit is an arm bit: it is never stored and always reads back as zero. Without it, software can only watch the flags, which the datapath sets as a side effect of its operations.

The block drives the rounding mode and the two trap enables straight out to the datapath. When an enabled exception fires, it raises a one-cycle trap request.

Top module: `fpcsr_top`

## Requirements
- R1: After reset the mode register reads 0x00000100, the flag register reads 0x00000000, `rnd_mode` is 2'b01 and both trap enables are 0.
- R2: A write to address 0x300 stores write-data bit 0 (invalid trap enable), bit 1 (divide-by-zero trap enable) and bits [9:8] (rounding mode). All other bits of the mode register read as 0 whatever was written.
- R3: `rnd_mode` always equals mode-register bits [9:8], encoded as 00 toward zero, 01 to nearest, 10 toward plus infinity and 11 toward minus infinity. `trap_en_invalid` and `trap_en_divzero` equal mode bits 0 and 1.
- R4: A pulse on `evt_flags[i]` sets flag-register bit i. The bit order is 0 invalid, 1 divide by zero, 2 overflow, 3 underflow, 4 inexact. A set flag stays set until an armed software write clears it.
- R5: A write to address 0x301 with write-data bit 31 at 0 leaves every flag unchanged.
- R6: A write to address 0x301 with write-data bit 31 at 1 loads flag bits [4:0] from write-data bits [4:0], so it can both clear and set flags.
- R7: When an event and an armed flag write hit the same flag in the same cycle, the flag ends at 1.
- R8: Flag-register bit 31 and bits [30:5] always read as 0.
- R9: `trap_req` is high for exactly the one cycle after a cycle in which (`evt_flags[0]` and invalid trap enable) or (`evt_flags[1]` and divide-by-zero trap enable) held. The matching flag is set either way. With its enable at 0, an event raises no trap.
- R10: A read strobe in cycle n presents the register value from before that cycle's edge on `reg_rdata` from cycle n+1 on. `reg_rdata` holds until the next read. A write takes effect at the edge that ends its strobe cycle. Reads of any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| evt_flags | input | 5 | Exception event pulses from the datapath |
| rnd_mode | output | 2 | Current rounding mode |
| trap_en_invalid | output | 1 | Invalid-operation trap enable |
| trap_en_divzero | output | 1 | Divide-by-zero trap enable |
| trap_req | output | 1 | One-cycle trap request |

## Verification
A corrupted mode bit shows up on `rnd_mode` or a trap-enable output in the very next cycle. It also shows up on `reg_rdata` one cycle after a read of 0x300. A flag that wrongly sets or clears shows only through a read of 0x301, one cycle after the strobe. So the directed tests read the flag register right after each event burst and after each armed or unarmed write. A wrong trap decision appears on `trap_req` in the cycle after the event. The tests therefore sample that pin both in that cycle and in the one after it, to catch a missing pulse and a stretched one.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int FLAG_W  = 5;
    localparam int RM_LSB  = 8;
    localparam int F_INV   = 0;
    localparam int F_DZ    = 1;

    typedef enum logic [1:0] {
        RND_ZERO = 2'b00,
        RND_NEAR = 2'b01,
        RND_POS  = 2'b10,
        RND_NEG  = 2'b11
    } rnd_e;

    typedef struct packed {
        rnd_e rm;
        logic en_dz;
        logic en_inv;
    } mode_t;

    localparam mode_t MODE_RESET = '{rm: RND_NEAR, en_dz: 1'b0, en_inv: 1'b0};
endpackage

// File: rtl/fpcsr_mode_reg.sv
module fpcsr_mode_reg
    import fpcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wd_rm,
    input  logic       wd_en_dz,
    input  logic       wd_en_inv,
    output mode_t      mode_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else if (wr_en) begin
            mode_q.rm     <= rnd_e'(wd_rm);
            mode_q.en_dz  <= wd_en_dz;
            mode_q.en_inv <= wd_en_inv;
        end
    end
endmodule

// File: rtl/fpcsr_flag_bank.sv
module fpcsr_flag_bank
    import fpcsr_pkg::*;
#(
    parameter int NFLAG = FLAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_wr,
    input  logic [NFLAG-1:0] wd_flags,
    input  logic [NFLAG-1:0] evt,
    input  logic             en_inv,
    input  logic             en_dz,
    output logic [NFLAG-1:0] flags_q,
    output logic             trap_q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic base;
        always_comb base = armed_wr ? wd_flags[i] : flags_q[i];
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= base | evt[i];
        end
    end

    logic trap_d;
    always_comb trap_d = (evt[F_INV] & en_inv) | (evt[F_DZ] & en_dz);

    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= trap_d;
    end
endmodule

// File: rtl/fpcsr_read_port.sv
module fpcsr_read_port
    import fpcsr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              sel_mode,
    input  logic              sel_flag,
    input  mode_t             mode,
    input  logic [FLAG_W-1:0] flags,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mode_word, flag_word, rd_d;

    always_comb begin
        mode_word = '0;
        mode_word[RM_LSB +: 2] = mode.rm;
        mode_word[F_DZ]        = mode.en_dz;
        mode_word[F_INV]       = mode.en_inv;
        flag_word = '0;
        flag_word[FLAG_W-1:0]  = flags;
        unique case (1'b1)
            sel_mode: rd_d = mode_word;
            sel_flag: rd_d = flag_word;
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_d;
    end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
    import fpcsr_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 12'h300,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 12'h301
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [FLAG_W-1:0] evt_flags,
    output logic [1:0]        rnd_mode,
    output logic              trap_en_invalid,
    output logic              trap_en_divzero,
    output logic              trap_req
);
    localparam int ARM_BIT = DATA_W - 1;

    logic sel_mode, sel_flag, armed_wr;
    mode_t mode_q;
    logic [FLAG_W-1:0] flags_q;

    always_comb begin
        sel_mode = (reg_addr == MODE_ADDR);
        sel_flag = (reg_addr == FLAG_ADDR);
        armed_wr = reg_wr & sel_flag & reg_wdata[ARM_BIT];
    end

    fpcsr_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr & sel_mode),
        .wd_rm     (reg_wdata[RM_LSB +: 2]),
        .wd_en_dz  (reg_wdata[F_DZ]),
        .wd_en_inv (reg_wdata[F_INV]),
        .mode_q    (mode_q)
    );

    fpcsr_flag_bank #(.NFLAG(FLAG_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed_wr (armed_wr),
        .wd_flags (reg_wdata[FLAG_W-1:0]),
        .evt      (evt_flags),
        .en_inv   (mode_q.en_inv),
        .en_dz    (mode_q.en_dz),
        .flags_q  (flags_q),
        .trap_q   (trap_req)
    );

    fpcsr_read_port #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (reg_rd),
        .sel_mode (sel_mode),
        .sel_flag (sel_flag),
        .mode     (mode_q),
        .flags    (flags_q),
        .rdata    (reg_rdata)
    );

    always_comb begin
        rnd_mode        = mode_q.rm;
        trap_en_invalid = mode_q.en_inv;
        trap_en_divzero = mode_q.en_dz;
    end
endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk
    import fpcsr_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 12'h300,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 12'h301
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [FLAG_W-1:0] evt_flags,
    input logic [FLAG_W-1:0] flags_q,
    input logic [1:0]        rnd_mode,
    input logic              trap_en_invalid,
    input logic              trap_en_divzero,
    input logic              trap_req
);
    logic armed, mode_wr, trig;
    always_comb begin
        armed   = reg_wr && reg_addr == FLAG_ADDR && reg_wdata[DATA_W-1];
        mode_wr = reg_wr && reg_addr == MODE_ADDR;
        trig    = (evt_flags[F_INV] && trap_en_invalid) || (evt_flags[F_DZ] && trap_en_divzero);
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flags != '0) |=> ((flags_q & $past(evt_flags)) == $past(evt_flags))); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable({rnd_mode, trap_en_invalid, trap_en_divzero})); // R3
    AST_TRAP_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> trap_req); // R9
    AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> !trap_req); // R9
    AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:10] == '0); // R8
endmodule

bind fpcsr_top fpcsr_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .evt_flags(evt_flags), .flags_q(flags_q),
    .rnd_mode(rnd_mode), .trap_en_invalid(trap_en_invalid),
    .trap_en_divzero(trap_en_divzero), .trap_req(trap_req)
);

// File: tb/fpcsr_top_tb_top.sv
module fpcsr_top_tb_top;
    localparam logic [11:0] A_MODE = 12'h300;
    localparam logic [11:0] A_FLAG = 12'h301;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [4:0]  evt_flags = '0;
    logic [1:0]  rnd_mode;
    logic        trap_en_invalid, trap_en_divzero, trap_req;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fpcsr_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .evt_flags(evt_flags), .rnd_mode(rnd_mode),
        .trap_en_invalid(trap_en_invalid), .trap_en_divzero(trap_en_divzero),
        .trap_req(trap_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [4:0] e, input logic exp_trap, input string req);
        evt_flags = e;
        @(negedge clk);
        evt_flags = '0;
        check(req, {31'd0, trap_req}, {31'd0, exp_trap});
        @(negedge clk);
        check(req, {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1", {29'd0, rnd_mode, trap_en_invalid}, {29'd0, 2'b01, 1'b0});
        check("R1", {31'd0, trap_en_divzero}, 32'd0);
        rd_chk(A_MODE, 32'h0000_0100, "R1");
        rd_chk(A_FLAG, 32'h0, "R1");
    endtask

    task automatic t_mode();
        wr(A_MODE, 32'hFFFF_FFFF);
        rd_chk(A_MODE, 32'h0000_0303, "R2");
        check("R3", {30'd0, rnd_mode}, 32'd3);
        check("R3", {30'd0, trap_en_divzero, trap_en_invalid}, 32'd3);
        for (int m = 0; m < 4; m++) begin
            wr(A_MODE, 32'(m) << 8);
            check("R3", {30'd0, rnd_mode}, 32'(m));
            rd_chk(A_MODE, 32'(m) << 8, "R2");
        end
        wr(A_MODE, 32'h0000_0102);
        check("R3", {30'd0, trap_en_divzero, trap_en_invalid}, 32'd2);
    endtask

    task automatic t_flags();
        logic [4:0] acc = '0;
        wr(A_MODE, 32'h0000_0100);
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i), 1'b0, "R4");
            acc |= 5'(1 << i);
            rd_chk(A_FLAG, {27'd0, acc}, "R4");
        end
        wr(A_FLAG, 32'h0000_0000);
        rd_chk(A_FLAG, 32'h0000_001F, "R5");
        wr(A_FLAG, 32'h0000_0005);
        rd_chk(A_FLAG, 32'h0000_001F, "R5");
        wr(A_FLAG, 32'h8000_0000);
        rd_chk(A_FLAG, 32'h0, "R6");
        wr(A_FLAG, 32'hFFFF_FFF5);
        rd_chk(A_FLAG, 32'h0000_0015, "R8");
        wr(A_FLAG, 32'h8000_0000);
        evt_flags = 5'b00010;
        reg_addr = A_FLAG; reg_wdata = 32'h8000_0000; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_flags = '0;
        rd_chk(A_FLAG, 32'h0000_0002, "R7");
    endtask

    task automatic t_trap();
        wr(A_FLAG, 32'h8000_0000);
        wr(A_MODE, 32'h0000_0100);
        pulse(5'b00001, 1'b0, "R9");
        rd_chk(A_FLAG, 32'h1, "R9");
        wr(A_MODE, 32'h0000_0101);
        pulse(5'b00001, 1'b1, "R9");
        pulse(5'b00010, 1'b0, "R9");
        wr(A_MODE, 32'h0000_0103);
        pulse(5'b00010, 1'b1, "R9");
        pulse(5'b11100, 1'b0, "R9");
        rd_chk(A_FLAG, 32'h1F, "R9");
    endtask

    task automatic t_access();
        wr(A_MODE, 32'h0000_0200);
        wr(12'h302, 32'hFFFF_FFFF);
        rd_chk(A_MODE, 32'h0000_0200, "R10");
        rd_chk(12'h302, 32'h0, "R10");
        rd_chk(A_MODE, 32'h0000_0200, "R10");
        @(negedge clk);
        @(negedge clk);
        check("R10", reg_rdata, 32'h0000_0200);
        reg_addr = A_MODE; reg_wdata = 32'h0000_0300; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check("R10", reg_rdata, 32'h0000_0200);
        check("R10", {30'd0, rnd_mode}, 32'd3);
    endtask

    initial begin
        #(20 * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_flags();
        t_trap();
        t_access();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule